// File: doc/BRIEF.md
# Keyboard Command Responder

This block serves the host-facing side of a serial keyboard channel. Command bytes written by the host are decoded and, where a command calls for a reply, the block clears its receive queue and loads the reply bytes into it. Key events from the keyboard logic are turned into scancodes and appended to the same queue, which the host drains one byte at a time.

The receive queue is a circular buffer with a read pointer, a write pointer and an entry count. A command that produces a reply loads the whole reply in one cycle, because the queue is known to be empty once it has been cleared. The caps-lock and num-lock keys pass through a two-bit toggle state, so that a physical toggle key reports only every other press and every other release. An interrupt pulse tells the host that data is waiting.

Top module: `kbd_cmd_responder`

## Requirements
- R1: When a live command byte of 0x01 is accepted, the queue is cleared and then holds exactly 0xFF, 0x04, 0x7F in that read order.
- R2: When a live command byte of 0x07 or 0x0F is accepted, the queue is cleared and then holds exactly 0xFE, 0x21 in that read order.
- R3: A command byte of 0x0E arms a skip flag. The next command byte, whatever its value, has no effect, and it clears the flag.
- R4: A live command byte other than 0x01, 0x07, 0x0E and 0x0F leaves the queue contents unchanged.
- R5: A key press enqueues {1'b0, code}. A key release enqueues {1'b1, code}, which is the code OR 0x80.
- R6: Each lock key (code CAPS_KEY or NUM_KEY) has its own two-bit state. A press flips bit 0 and is dropped when the new state is 2. A release flips bit 1 and is dropped when the new state is 3. From reset the pattern is: press sent, release dropped, press dropped, release sent.
- R7: A push into a queue that holds DEPTH entries is discarded. A push and a pop in the same cycle on a queue that is neither empty nor full leave the count unchanged and keep the FIFO order.
- R8: While the queue is empty, rd_data reads 0 and a pop has no effect.
- R9: irq is a one-cycle pulse in the cycle after an entry is enqueued, or after a pop that leaves at least one entry.
- R10: Reset empties the queue, clears the skip flag and clears both lock states. irq is low during reset.
- R11: A key event in the same cycle as a clearing command is enqueued directly after the reply bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte strobe from the host |
| cmd_byte | input | 8 | Command byte |
| key_valid | input | 1 | Key event strobe |
| key_code | input | 7 | Key code |
| key_down | input | 1 | 1 for a press, 0 for a release |
| pop | input | 1 | Remove the head entry |
| rd_data | output | 8 | Head entry, or 0 when empty |
| not_empty | output | 1 | Queue holds at least one entry |
| irq | output | 1 | Data-available interrupt pulse |

## Verification
The bench builds the block with DEPTH set to 8 and the default lock-key codes. The small depth lets a burst of ten key presses overrun the queue, so the discard rule and the pointer wrap can be checked within a few dozen cycles. The same settings also cover the three- and four-entry reply loads, including the case where a key event lands in the same cycle as a clearing command.

// File: rtl/kbd_cmd_responder.sv
module kbd_cmd_responder #(
  parameter int        DEPTH    = 256,
  parameter logic [6:0] CAPS_KEY = 7'h77,
  parameter logic [6:0] NUM_KEY  = 7'h62
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       key_valid,
  input  logic [6:0] key_code,
  input  logic       key_down,
  input  logic       pop,
  output logic [7:0] rd_data,
  output logic       not_empty,
  output logic       irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          led_q;
  logic [1:0]    caps_st, num_st;
  logic          irq_q;

  wire cmd_live  = cmd_valid & ~led_q;
  wire is_reset  = cmd_live & (cmd_byte == 8'h01);
  wire is_layout = cmd_live & ((cmd_byte == 8'h07) | (cmd_byte == 8'h0F));
  wire flush     = is_reset | is_layout;

  wire is_caps = key_code == CAPS_KEY;
  wire is_num  = key_code == NUM_KEY;

  logic [1:0] lock_cur, lock_nxt;
  logic       key_drop;
  always_comb begin
    lock_cur = is_caps ? caps_st : num_st;
    lock_nxt = key_down ? (lock_cur ^ 2'b01) : (lock_cur ^ 2'b10);
    key_drop = (is_caps | is_num) &
               (key_down ? (lock_nxt == 2'd2) : (lock_nxt == 2'd3));
  end

  wire       key_push = key_valid & ~key_drop;
  wire [7:0] key_byte = {~key_down, key_code};

  wire empty  = count == '0;
  wire full   = count == CW'(DEPTH);
  wire pop_ok = pop & ~empty;
  wire push_ok = key_push & ~full;

  wire [AW-1:0] reply_len = is_reset ? AW'(3) : AW'(2);

  always_ff @(posedge clk) begin
    if (flush) begin
      mem[AW'(0)] <= is_reset ? 8'hFF : 8'hFE;
      mem[AW'(1)] <= is_reset ? 8'h04 : 8'h21;
      if (is_reset) mem[AW'(2)] <= 8'h7F;
      if (key_push) mem[reply_len] <= key_byte;
    end else if (push_ok) begin
      mem[wr_ptr] <= key_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      irq_q  <= 1'b0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= reply_len + AW'(key_push);
      count  <= CW'(reply_len) + CW'(key_push);
      irq_q  <= 1'b1;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
      count <= count + CW'(push_ok) - CW'(pop_ok);
      irq_q <= push_ok | (pop_ok & (count > CW'(1)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led_q   <= 1'b0;
      caps_st <= 2'd0;
      num_st  <= 2'd0;
    end else begin
      if (cmd_valid) led_q <= ~led_q & (cmd_byte == 8'h0E);
      if (key_valid & is_caps) caps_st <= lock_nxt;
      if (key_valid & is_num)  num_st  <= lock_nxt;
    end
  end

  assign not_empty = ~empty;
  assign rd_data   = empty ? 8'h00 : mem[rd_ptr];
  assign irq       = irq_q;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R7
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && key_valid && !pop && !cmd_valid) |=> (count == CW'(DEPTH))); // R7
  AST_REPLY_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !led_q && cmd_byte == 8'h01) |=> (rd_data == 8'hFF && count >= CW'(3))); // R1
  AST_SKIP_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (led_q && cmd_valid) |=> !led_q); // R3
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !key_valid && !cmd_valid) |=> !not_empty); // R8
  AST_IRQ_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> not_empty); // R9
endmodule

// File: tb/kbd_cmd_responder_bench.sv
module kbd_cmd_responder_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic key_valid = 1'b0;
  logic [6:0] key_code = 7'h00;
  logic key_down = 1'b0;
  logic pop = 1'b0;
  logic [7:0] rd_data;
  logic not_empty;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  kbd_cmd_responder #(.DEPTH(8)) u_kbd_cmd_responder (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .key_valid(key_valid), .key_code(key_code), .key_down(key_down),
    .pop(pop), .rd_data(rd_data), .not_empty(not_empty), .irq(irq));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk); cmd_valid = 1'b1; cmd_byte = b;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic send_key(input logic [6:0] c, input logic d);
    @(negedge clk); key_valid = 1'b1; key_code = c; key_down = d;
    @(negedge clk); key_valid = 1'b0;
  endtask

  task automatic expect_byte(input logic [7:0] b);
    exp_q.push_back(b);
  endtask

  task automatic pop_check(input string tag);
    logic [7:0] e;
    e = exp_q.pop_front();
    chk(not_empty === 1'b1, {tag, " not_empty"}, int'(not_empty), 1);
    chk(rd_data === e, tag, int'(rd_data), int'(e));
    pop = 1'b1;
    @(negedge clk); pop = 1'b0;
  endtask

  task automatic drain(input string tag);
    while (exp_q.size() > 0) pop_check(tag);
    chk(not_empty === 1'b0, {tag, " empty after drain"}, int'(not_empty), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(not_empty === 1'b0 && rd_data === 8'h00 && irq === 1'b0, "R10 reset state",
        int'({not_empty, irq, rd_data}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    send_key(7'h1C, 1'b1);
    chk(irq === 1'b1, "R9 irq after push", int'(irq), 1);
    @(negedge clk);
    chk(irq === 1'b0, "R9 irq single pulse", int'(irq), 0);
    expect_byte(8'h1C);
    send_key(7'h1C, 1'b0); expect_byte(8'h9C);
    drain("R5 make/break");

    send_key(7'h05, 1'b1); send_key(7'h06, 1'b1);
    send_cmd(8'h01);
    expect_byte(8'hFF); expect_byte(8'h04); expect_byte(8'h7F);
    drain("R1 reset reply");

    send_cmd(8'h07);
    expect_byte(8'hFE); expect_byte(8'h21);
    drain("R2 layout 0x07");
    send_key(7'h10, 1'b1);
    send_cmd(8'h0F);
    expect_byte(8'hFE); expect_byte(8'h21);
    drain("R2 layout 0x0F flush");

    send_key(7'h20, 1'b1);
    send_cmd(8'h55); send_cmd(8'h00); send_cmd(8'hFF);
    expect_byte(8'h20);
    drain("R4 unknown commands");

    send_cmd(8'h0E); send_cmd(8'h01);
    chk(not_empty === 1'b0, "R3 byte after LED skipped", int'(not_empty), 0);
    send_cmd(8'h01);
    expect_byte(8'hFF); expect_byte(8'h04); expect_byte(8'h7F);
    drain("R3 command after skip");
    send_cmd(8'h0E); send_cmd(8'h0E); send_cmd(8'h07);
    expect_byte(8'hFE); expect_byte(8'h21);
    drain("R3 second 0x0E skipped");

    send_key(7'h77, 1'b1); expect_byte(8'h77);
    send_key(7'h77, 1'b0);
    send_key(7'h77, 1'b1);
    send_key(7'h62, 1'b1); expect_byte(8'h62);
    send_key(7'h77, 1'b0); expect_byte(8'hF7);
    send_key(7'h77, 1'b1); expect_byte(8'h77);
    drain("R6 lock filter");

    for (int i = 0; i < 10; i++) begin
      send_key(7'(8'h30 + i), 1'b1);
      if (i < 8) expect_byte(8'(8'h30 + i));
    end
    drain("R7 full discard");

    send_key(7'h41, 1'b1); send_key(7'h42, 1'b1);
    @(negedge clk);
    chk(rd_data === 8'h41, "R7 head before push+pop", int'(rd_data), 8'h41);
    pop = 1'b1; key_valid = 1'b1; key_code = 7'h43; key_down = 1'b1;
    @(negedge clk); pop = 1'b0; key_valid = 1'b0;
    expect_byte(8'h42); expect_byte(8'h43);
    drain("R7 push+pop order");

    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
    chk(not_empty === 1'b0 && rd_data === 8'h00, "R8 empty pop", int'(rd_data), 0);
    send_key(7'h12, 1'b1); expect_byte(8'h12);
    drain("R8 pointers intact");

    send_key(7'h50, 1'b1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = 8'h01; key_valid = 1'b1; key_code = 7'h13; key_down = 1'b1;
    @(negedge clk); cmd_valid = 1'b0; key_valid = 1'b0;
    expect_byte(8'hFF); expect_byte(8'h04); expect_byte(8'h7F); expect_byte(8'h13);
    drain("R11 key with command");

    send_key(7'h21, 1'b1); send_key(7'h22, 1'b1);
    @(negedge clk);
    pop = 1'b1; @(negedge clk); pop = 1'b0;
    chk(irq === 1'b1, "R9 irq after pop with data left", int'(irq), 1);
    pop = 1'b1; @(negedge clk); pop = 1'b0;
    chk(irq === 1'b0, "R9 no irq after last pop", int'(irq), 0);

    send_key(7'h77, 1'b0);
    send_cmd(8'h0E);
    send_key(7'h33, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk(not_empty === 1'b0, "R10 reset empties queue", int'(not_empty), 0);
    send_cmd(8'h01);
    expect_byte(8'hFF); expect_byte(8'h04); expect_byte(8'h7F);
    drain("R10 skip flag cleared");
    send_key(7'h77, 1'b1); expect_byte(8'h77);
    drain("R10 lock state cleared");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule